// File: doc/BRIEF.md
# Calibration Trigger Sequencer

This block decides when a converter's self-calibration engine is launched. After power-on reset it waits a selectable settling delay and then starts one calibration on its own. Later calibrations are requested through a single noisy command line that must be cleanly low for a qualifying run and then cleanly high for a qualifying run. Brief glitches therefore cannot launch a calibration.

While a calibration runs, the block holds a busy flag and withholds the output data clock. It also coordinates with a power-down request. Power-down is postponed while a calibration is in flight. Holding power-down after reset stalls the settling delay. The calibration algorithm lives elsewhere and reports completion through a one-cycle done pulse.

Top module: `cal_trigger_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `cal_start` = 0, `cal_run` = 0, `pd_active` = 0 and `dclk_enable` = 1.
- R2: Edges are counted from the first rising edge with `rst` low (edge 1). With `cal_cmd` low at reset and `pd_req` low, `cal_start` is high after edge D+1. D is SHORT_DLY (256) when `dly_sel` = 0 and LONG_DLY (4096) when `dly_sel` = 1. Only one power-on calibration is launched.
- R3: When `ext_mode` = 1, `dly_sel` has no effect and D is always SHORT_DLY.
- R4: Each edge at which `pd_req` is sampled high postpones the power-on start by one edge. No calibration starts on an edge where `pd_req` is sampled high.
- R5: If `cal_cmd` is high during reset, no power-on calibration is launched.
- R6: A command is accepted when `cal_cmd` is sampled low on at least 80 consecutive edges and then high on at least 80 consecutive edges. `cal_start` is high after the edge that follows the 80th high sample. A run of 79 low or 79 high samples launches nothing.
- R7: Any interruption of a low or high run restarts the count of that run from zero.
- R8: `cal_start` is high for exactly one cycle, and `cal_run` rises on the same edge.
- R9: `cal_run` falls on the edge at which `cal_done` is sampled high. `cal_done` has no effect while no calibration runs.
- R10: `dclk_enable` is 0 whenever `cal_run` or `pd_active` is 1, and 1 otherwise.
- R11: A qualifying command seen while `cal_run` is high is discarded. A fresh low run and high run are needed afterwards.
- R12: If `pd_req` is high during a calibration, `pd_active` stays 0 until `cal_run` falls and rises on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cal_cmd | input | 1 | Raw calibration command line |
| dly_sel | input | 1 | Power-on delay choice: 0 short, 1 long |
| pd_req | input | 1 | Power-down request |
| ext_mode | input | 1 | Extended control mode, forces the short delay |
| cal_done | input | 1 | One-cycle completion pulse from the calibration engine |
| cal_start | output | 1 | One-cycle launch pulse to the calibration engine |
| cal_run | output | 1 | Calibration in progress |
| dclk_enable | output | 1 | Output data clock gate |
| pd_active | output | 1 | Device is in power-down |

## Verification
A miscounting run qualifier shows up as a launch one edge early or late, or as a launch after a 79-cycle run. The bench timestamps every `cal_start` pulse and checks it against the exact edge predicted from the stimulus. A wrong delay limit or a stuck pending flag shifts or suppresses the power-on launch by hundreds of cycles and is caught on the first run of each delay setting. Errors in the busy or power-down state appear on `cal_run`, `pd_active` or `dclk_enable` within one cycle of `cal_start` or `cal_done`.

// File: rtl/calseq_pkg.sv
package calseq_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_t;
endpackage

// File: rtl/cal_run_qualifier.sv
// Debounces the command line: needs QUAL low samples, then QUAL high samples.
module cal_run_qualifier #(
  parameter int QUAL = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic cal_cmd,
  output logic cmd_fire
);
  localparam int CW = $clog2(QUAL + 1);
  localparam logic [CW-1:0] QMAX = CW'(QUAL);
  localparam logic [CW-1:0] QLAST = CW'(QUAL - 1);

  logic [CW-1:0] low_cnt, high_cnt;
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt  <= '0;
      high_cnt <= '0;
      armed    <= 1'b0;
      cmd_fire <= 1'b0;
    end else begin
      cmd_fire <= 1'b0;
      if (!cal_cmd) begin
        high_cnt <= '0;
        armed    <= 1'b0;
        if (low_cnt != QMAX) low_cnt <= low_cnt + 1'b1;
      end else begin
        low_cnt <= '0;
        if (high_cnt != QMAX) high_cnt <= high_cnt + 1'b1;
        if (low_cnt != '0) begin
          // first high sample: arm only if preceding low run qualified
          armed <= (low_cnt == QMAX);
        end else if (armed && high_cnt == QLAST) begin
          cmd_fire <= 1'b1;
          armed    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/por_delay_timer.sv
// Settling delay before the power-on calibration.
module por_delay_timer #(
  parameter int SHORT_DLY = 256,
  parameter int LONG_DLY  = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic cal_cmd,
  input  logic dly_sel,
  input  logic ext_mode,
  input  logic pd_req,
  input  logic start_seen,
  output logic due
);
  localparam int CW = $clog2(LONG_DLY + 1);
  localparam logic [CW-1:0] SHORT_C = CW'(SHORT_DLY);
  localparam logic [CW-1:0] LONG_C  = CW'(LONG_DLY);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic pending;

  always_comb begin
    limit = (ext_mode || !dly_sel) ? SHORT_C : LONG_C;
    due   = pending && (cnt >= limit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pending <= !cal_cmd;
    end else begin
      if (start_seen) pending <= 1'b0;
      if (pending && !pd_req && cnt < limit) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cal_ctrl_fsm.sv
// Launch, busy tracking, power-down deferral and data clock gating.
module cal_ctrl_fsm
  import calseq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_fire,
  input  logic por_due,
  input  logic pd_req,
  input  logic cal_done,
  output logic cal_start,
  output logic cal_run,
  output logic dclk_enable,
  output logic pd_active
);
  seq_state_t state, state_nx;
  logic start_nx, pd_nx;

  always_comb begin
    state_nx = state;
    start_nx = 1'b0;
    pd_nx    = pd_active;
    unique case (state)
      SEQ_IDLE: begin
        pd_nx = pd_req;
        if ((cmd_fire || por_due) && !pd_req) begin
          start_nx = 1'b1;
          state_nx = SEQ_BUSY;
          pd_nx    = 1'b0;
        end
      end
      SEQ_BUSY: begin
        pd_nx = 1'b0;
        if (cal_done) begin
          state_nx = SEQ_IDLE;
          pd_nx    = pd_req;
        end
      end
      default: state_nx = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SEQ_IDLE;
      cal_start   <= 1'b0;
      cal_run     <= 1'b0;
      pd_active   <= 1'b0;
      dclk_enable <= 1'b1;
    end else begin
      state       <= state_nx;
      cal_start   <= start_nx;
      cal_run     <= (state_nx == SEQ_BUSY);
      pd_active   <= pd_nx;
      dclk_enable <= !((state_nx == SEQ_BUSY) || pd_nx);
    end
  end
endmodule

// File: rtl/cal_trigger_seq.sv
module cal_trigger_seq #(
  parameter int QUAL_CYCLES = 80,
  parameter int SHORT_DLY   = 256,
  parameter int LONG_DLY    = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic cal_cmd,
  input  logic dly_sel,
  input  logic pd_req,
  input  logic ext_mode,
  input  logic cal_done,
  output logic cal_start,
  output logic cal_run,
  output logic dclk_enable,
  output logic pd_active
);
  logic cmd_fire, por_due;

  cal_run_qualifier #(.QUAL(QUAL_CYCLES)) u_qual (
    .clk(clk), .rst(rst), .cal_cmd(cal_cmd), .cmd_fire(cmd_fire)
  );

  por_delay_timer #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_por (
    .clk(clk), .rst(rst), .cal_cmd(cal_cmd), .dly_sel(dly_sel),
    .ext_mode(ext_mode), .pd_req(pd_req), .start_seen(cal_start), .due(por_due)
  );

  cal_ctrl_fsm u_ctrl (
    .clk(clk), .rst(rst), .cmd_fire(cmd_fire), .por_due(por_due),
    .pd_req(pd_req), .cal_done(cal_done), .cal_start(cal_start),
    .cal_run(cal_run), .dclk_enable(dclk_enable), .pd_active(pd_active)
  );
endmodule

// File: rtl/cal_trigger_chk.sv
module cal_trigger_chk (
  input logic clk,
  input logic rst,
  input logic pd_req,
  input logic cal_done,
  input logic cal_start,
  input logic cal_run,
  input logic dclk_enable,
  input logic pd_active
);
  a_r8_start_single: assert property (@(posedge clk) disable iff (rst)
    cal_start |=> !cal_start);
  a_r8_run_with_start: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_run) |-> cal_start);
  a_r9_done_ends_run: assert property (@(posedge clk) disable iff (rst)
    (cal_run && cal_done) |=> !cal_run);
  a_r10_no_clk_busy: assert property (@(posedge clk) disable iff (rst)
    (cal_run || pd_active) |-> !dclk_enable);
  a_r12_pd_deferred: assert property (@(posedge clk) disable iff (rst)
    cal_run |-> !pd_active);
  a_r4_no_start_in_pd: assert property (@(posedge clk) disable iff (rst)
    cal_start |-> !$past(pd_req));
endmodule

bind cal_trigger_seq cal_trigger_chk u_chk (
  .clk(clk), .rst(rst), .pd_req(pd_req), .cal_done(cal_done),
  .cal_start(cal_start), .cal_run(cal_run), .dclk_enable(dclk_enable),
  .pd_active(pd_active)
);

// File: tb/tb_cal_trigger_seq.sv
module tb_cal_trigger_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SHORT_D = 256;
  localparam int LONG_D = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cal_cmd = 1'b0, dly_sel = 1'b0, pd_req = 1'b0, ext_mode = 1'b0, cal_done = 1'b0;
  logic cal_start, cal_run, dclk_enable, pd_active;

  int n_chk = 0, n_bad = 0;
  int ecnt = 0, nstarts = 0, last_start = 0;
  bit finished = 0;

  cal_trigger_seq dut (
    .clk(clk), .rst(rst), .cal_cmd(cal_cmd), .dly_sel(dly_sel), .pd_req(pd_req),
    .ext_mode(ext_mode), .cal_done(cal_done), .cal_start(cal_start),
    .cal_run(cal_run), .dclk_enable(dclk_enable), .pd_active(pd_active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rst) ecnt = 0; else ecnt = ecnt + 1;
  always @(negedge clk) if (!rst && cal_start) begin
    nstarts = nstarts + 1;
    last_start = ecnt;
  end

  function automatic bit cmd_expected(int lo, int hi);
    return (lo >= 80) && (hi >= 80);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold_cmd(logic v, int n);
    cal_cmd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic c, logic sel, logic ext, logic pd);
    @(negedge clk);
    rst = 1'b1; cal_cmd = c; dly_sel = sel; ext_mode = ext; pd_req = pd; cal_done = 1'b0;
    repeat (3) @(negedge clk);
    check(!cal_start && !cal_run && !pd_active && dclk_enable, "R1 reset outputs",
          {cal_start, cal_run, pd_active, dclk_enable}, 4'b0001);
    rst = 1'b0;
    nstarts = 0;
  endtask

  task automatic wait_start(int maxc);
    int n0 = nstarts;
    for (int i = 0; i < maxc && nstarts == n0; i++) @(negedge clk);
  endtask

  task automatic end_cal(string req);
    cal_done = 1'b1;
    @(negedge clk);
    cal_done = 1'b0;
    check(!cal_run, req, cal_run, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int s0, e0, lo, hi;
    bit exp;
    void'($urandom(32'h5EED_0042));

    // R1, R2 short delay
    do_reset(0, 0, 0, 0);
    check(!cal_start && !cal_run && dclk_enable, "R1 first cycle", cal_run, 0);
    wait_start(SHORT_D + 20);
    check(last_start == SHORT_D + 1 && nstarts == 1, "R2 short delay", last_start, SHORT_D + 1);
    check(cal_run && !dclk_enable, "R10 clock gated in cal", dclk_enable, 0);
    repeat (3) @(negedge clk);
    check(nstarts == 1 && !cal_start, "R8 single pulse", nstarts, 1);
    end_cal("R9 run drops on done");
    check(dclk_enable, "R10 clock back", dclk_enable, 1);
    repeat (600) @(negedge clk);
    check(nstarts == 1, "R2 only one power-on start", nstarts, 1);
    cal_done = 1'b1; @(negedge clk); cal_done = 1'b0; @(negedge clk);
    check(!cal_run && nstarts == 1, "R9 done while idle ignored", cal_run, 0);

    // R2 long delay
    do_reset(0, 1, 0, 0);
    wait_start(LONG_D + 20);
    check(last_start == LONG_D + 1, "R2 long delay", last_start, LONG_D + 1);
    end_cal("R9 end");

    // R3 extended mode forces short
    do_reset(0, 1, 1, 0);
    wait_start(LONG_D + 20);
    check(last_start == SHORT_D + 1, "R3 ext forces short", last_start, SHORT_D + 1);
    end_cal("R9 end");

    // R4 pd held after reset
    do_reset(0, 0, 0, 1);
    repeat (100) @(negedge clk);
    check(pd_active && !dclk_enable && nstarts == 0, "R4 pd active, no start", nstarts, 0);
    pd_req = 1'b0;
    wait_start(SHORT_D + 20);
    check(last_start == SHORT_D + 101, "R4 delay frozen by pd", last_start, SHORT_D + 101);
    end_cal("R9 end");

    // R5 cmd high at reset cancels power-on cal, then R6 exact timing
    do_reset(1, 0, 0, 0);
    repeat (400) @(negedge clk);
    check(nstarts == 0, "R5 power-on skipped", nstarts, 0);
    hold_cmd(0, 80);
    e0 = ecnt;
    hold_cmd(1, 80);
    hold_cmd(0, 4);
    check(nstarts == 1 && last_start == e0 + 81, "R6 80/80 launch edge", last_start, e0 + 81);
    end_cal("R9 end");

    // R6 boundaries
    s0 = nstarts;
    hold_cmd(1, 3); hold_cmd(0, 79); hold_cmd(1, 80); hold_cmd(0, 5);
    check(nstarts == s0, "R6 low 79 rejected", nstarts, s0);
    hold_cmd(1, 3); hold_cmd(0, 80); hold_cmd(1, 79); hold_cmd(0, 5);
    check(nstarts == s0, "R6 high 79 rejected", nstarts, s0);

    // R7 interrupted runs
    hold_cmd(1, 3); hold_cmd(0, 50); hold_cmd(1, 1); hold_cmd(0, 50); hold_cmd(1, 80); hold_cmd(0, 5);
    check(nstarts == s0, "R7 low run broken", nstarts, s0);
    hold_cmd(1, 3); hold_cmd(0, 80); hold_cmd(1, 40); hold_cmd(0, 1); hold_cmd(1, 80); hold_cmd(0, 5);
    check(nstarts == s0, "R7 high run broken", nstarts, s0);

    // R11 command during calibration
    hold_cmd(1, 3); hold_cmd(0, 80); hold_cmd(1, 80); hold_cmd(0, 5);
    check(nstarts == s0 + 1 && cal_run, "R6 launch", nstarts, s0 + 1);
    hold_cmd(0, 80); hold_cmd(1, 80); hold_cmd(0, 5);
    check(nstarts == s0 + 1 && cal_run, "R11 busy command ignored", nstarts, s0 + 1);
    end_cal("R9 end");
    repeat (20) @(negedge clk);
    check(nstarts == s0 + 1, "R11 no late launch", nstarts, s0 + 1);

    // R12 power-down deferral
    hold_cmd(1, 3); hold_cmd(0, 80); hold_cmd(1, 80); hold_cmd(0, 5);
    pd_req = 1'b1;
    repeat (5) @(negedge clk);
    check(!pd_active && cal_run, "R12 pd deferred", pd_active, 0);
    cal_done = 1'b1; @(negedge clk); cal_done = 1'b0;
    check(pd_active && !cal_run && !dclk_enable, "R12 pd after done", pd_active, 1);
    pd_req = 1'b0;
    @(negedge clk);
    check(!pd_active && dclk_enable, "R10 clock after pd", dclk_enable, 1);

    // random run lengths
    for (int t = 0; t < 16; t++) begin
      lo = 76 + int'($urandom_range(8));
      hi = 76 + int'($urandom_range(8));
      exp = cmd_expected(lo, hi);
      s0 = nstarts;
      hold_cmd(1, 3); hold_cmd(0, lo);
      e0 = ecnt;
      hold_cmd(1, hi); hold_cmd(0, 4);
      check(nstarts == s0 + int'(exp), "R6 random runs", nstarts - s0, int'(exp));
      if (exp) begin
        check(last_start == e0 + 81, "R6 random launch edge", last_start, e0 + 81);
        end_cal("R9 end");
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule